// File: doc/BRIEF.md
# Serial Link Transmit Framer

This block sits between a payload source and a serial storage link's line coder. It takes 32-bit payload dwords with a last-dword flag and produces, one dword per clock, the framed transmit stream: a 32-bit word and a 4-bit control flag that marks which byte, if any, is a control character. Each frame starts with a start primitive and is followed by the payload and a CRC dword. The payload and CRC are XORed with a running scrambler. A closing end primitive finishes the frame.

Between frames the link idles on the synchronisation primitive. A run of identical primitives is shortened: the primitive is sent twice, then one continue primitive, then scrambled filler dwords until something else must be sent. The source may abort a frame in progress with a one-cycle request. The framer then drops the rest of the frame and sends the synchronisation primitive in its place. A source that stops supplying dwords in the middle of a payload is treated the same way.

Top module: `lnk_tx_framer`

## Requirements
- R1: While `rst` is high, and on the first output after any clock edge with `rst` high, the output is the synchronisation primitive with `tx_ctl` = 4'b0001 and `in_ready` is low. The scrambler register is set to 16'hFFFF.
- R2: `tx_ctl` is 4'b0001 (byte 0 is a control character) for every primitive and 4'b0000 for payload, CRC and filler words. The primitive codes are: sync 32'hB5B5957C, start 32'h3737B57C, end 32'hD5D5B57C, continue 32'h9999AA7C.
- R3: A clock edge that sees `in_valid` high while idle outputs the start primitive. After that, one payload dword leaves per accepted cycle, in order, then the CRC dword, then the end primitive. `in_ready` is high only while payload dwords are being taken.
- R4: The CRC uses polynomial 32'h04C11DB7 and is seeded with 32'h52325032 at each start primitive. It folds in the unscrambled payload MSB first, with no reflection and no final inversion, and goes out as the dword just before the end primitive.
- R5: The scrambler is a 16-bit Fibonacci LFSR for x^16+x^15+x^13+x^4+1. Each step outputs bit 15, then shifts left with feedback bit15^bit14^bit12^bit3. One dword takes 32 steps, with the first output bit placed at dword bit 0. The LFSR reloads 16'hFFFF on the start primitive and advances once per payload, CRC or filler dword, never on a primitive.
- R6: When a primitive is due for the third time in a row, the continue primitive goes out instead. Every further repeat goes out as a filler dword equal to the scrambler output with `tx_ctl` 4'b0000. Any data or different primitive ends the run.
- R7: `abort_req` high on an edge during the payload or CRC stage outputs the synchronisation primitive on that edge. No CRC or end primitive follows, the dword offered that cycle is not taken, and the framer returns to idle.
- R8: `in_valid` low on an edge during the payload stage has the same effect as an abort.
- R9: `abort_req` while idle has no effect on the output stream.
- R10: After the end primitive the framer returns to idle and sends the synchronisation primitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Payload dword offered |
| in_data | input | 32 | Payload dword |
| in_last | input | 1 | Offered dword is the last of the frame |
| in_ready | output | 1 | Offered dword is taken on this edge |
| abort_req | input | 1 | Abandon the current frame |
| tx_data | output | 32 | Framed transmit word |
| tx_ctl | output | 4 | Per-byte control-character flag |

## Verification
The abort path and the repeat compressor both act on the synchronisation primitive, and both can act in one cycle when an abort turns into idle fill. The bench aborts frames after the start primitive, in the middle of the payload and in the CRC stage, and starves one payload. It then checks that the first sync follows the last data word, that a second sync and a single continue come next, and that the filler resumes the scrambler sequence from the abort point. An abort pulsed into the idle filler is judged by the filler value continuing unchanged.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
    localparam int DW = 32;
    localparam int KW = DW / 8;
    localparam int LW = 16;

    localparam logic [LW-1:0] SCR_SEED = 16'hFFFF;
    localparam logic [LW-1:0] SCR_TAPS = 16'hD008;
    localparam logic [DW-1:0] CRC_SEED = 32'h52325032;
    localparam logic [DW-1:0] CRC_POLY = 32'h04C11DB7;

    localparam logic [KW-1:0] K_DATA = '0;
    localparam logic [KW-1:0] K_PRIM = {{(KW-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {PR_SYNC, PR_SOF, PR_EOF, PR_CONT} prim_e;
    typedef enum logic [1:0] {FS_IDLE, FS_BODY, FS_CRC, FS_EOF} fstate_e;
    typedef enum logic [1:0] {SL_WORD, SL_PRIM, SL_CONT, SL_FILL} sel_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [KW-1:0] ctl;
    } lane_t;

    typedef struct packed {
        logic [LW-1:0] st;
        logic [DW-1:0] word;
    } scr_t;

    function automatic logic [DW-1:0] prim_code(input prim_e p);
        case (p)
            PR_SOF:  return 32'h3737B57C;
            PR_EOF:  return 32'hD5D5B57C;
            PR_CONT: return 32'h9999AA7C;
            default: return 32'hB5B5957C;
        endcase
    endfunction

    function automatic scr_t scr_gen(input logic [LW-1:0] st);
        scr_t r;
        r.st   = st;
        r.word = '0;
        for (int b = 0; b < DW; b++) begin
            r.word[b] = r.st[LW-1];
            r.st      = {r.st[LW-2:0], ^(r.st & SCR_TAPS)};
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] crc_fold(input logic [DW-1:0] c,
                                               input logic [DW-1:0] d,
                                               input logic [DW-1:0] poly);
        logic [DW-1:0] r;
        logic          fb;
        r = c;
        for (int b = DW - 1; b >= 0; b--) begin
            fb = r[DW-1] ^ d[b];
            r  = {r[DW-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return r;
    endfunction
endpackage

// File: rtl/lnk_tx_scr.sv
module lnk_tx_scr
    import lnk_tx_pkg::*;
#(
    parameter logic [LW-1:0] INIT = SCR_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          advance,
    output logic [DW-1:0] word
);
    logic [LW-1:0] st_q;
    scr_t          gen;

    assign gen  = scr_gen(st_q);
    assign word = gen.word;

    always_ff @(posedge clk) begin
        if (rst || restart) st_q <= INIT;
        else if (advance)   st_q <= gen.st;
    end

    // R5
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);
endmodule

// File: rtl/lnk_tx_crc.sv
module lnk_tx_crc
    import lnk_tx_pkg::*;
#(
    parameter logic [DW-1:0] INIT = CRC_SEED,
    parameter logic [DW-1:0] POLY = CRC_POLY
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          update,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] crc
);
    logic [DW-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || restart) crc_q <= INIT;
        else if (update)    crc_q <= crc_fold(crc_q, din, POLY);
    end

    assign crc = crc_q;
endmodule

// File: rtl/lnk_tx_cont.sv
module lnk_tx_cont
    import lnk_tx_pkg::*;
#(
    parameter int RUN_W = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  want_prim,
    input  prim_e prim,
    output sel_e  sel
);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
    localparam logic [RUN_W-1:0] RUN_TWO  = RUN_W'(2);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(3);

    prim_e            last_q, last_d;
    logic [RUN_W-1:0] rep_q, rep_d;

    always_comb begin
        sel    = SL_WORD;
        last_d = last_q;
        rep_d  = rep_q;
        if (!want_prim) begin
            rep_d = '0;
        end else if (rep_q != '0 && prim == last_q) begin
            if (rep_q == RUN_ONE) begin
                sel   = SL_PRIM;
                rep_d = RUN_TWO;
            end else if (rep_q == RUN_TWO) begin
                sel   = SL_CONT;
                rep_d = RUN_FULL;
            end else begin
                sel   = SL_FILL;
            end
        end else begin
            sel    = SL_PRIM;
            last_d = prim;
            rep_d  = RUN_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PR_SYNC;
            rep_q  <= RUN_ONE;
        end else begin
            last_q <= last_d;
            rep_q  <= rep_d;
        end
    end

    // R6
    fill_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SL_FILL) |-> ($past(want_prim) && $past(prim) == prim));
endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
    import lnk_tx_pkg::*;
#(
    parameter logic [LW-1:0] SCR_INIT = SCR_SEED,
    parameter logic [DW-1:0] CRC_INIT = CRC_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    input  logic          abort_req,
    output logic [DW-1:0] tx_data,
    output logic [KW-1:0] tx_ctl
);
    fstate_e       fs_q, fs_d;
    lane_t         lane_q, lane_d;
    prim_e         want;
    sel_e          sel;
    logic          want_prim;
    logic [DW-1:0] body_w, scr_w, crc_w;
    logic          sof_go, accept, in_frame, scr_adv;

    assign in_frame = (fs_q == FS_BODY) || (fs_q == FS_CRC);
    assign in_ready = (fs_q == FS_BODY) && !abort_req;
    assign accept   = in_ready && in_valid;
    assign sof_go   = (fs_q == FS_IDLE) && in_valid;

    always_comb begin
        fs_d      = fs_q;
        want_prim = 1'b1;
        want      = PR_SYNC;
        body_w    = '0;
        case (fs_q)
            FS_IDLE: begin
                if (in_valid) begin
                    want = PR_SOF;
                    fs_d = FS_BODY;
                end
            end
            FS_BODY: begin
                if (abort_req || !in_valid) begin
                    fs_d = FS_IDLE;
                end else begin
                    want_prim = 1'b0;
                    body_w    = in_data;
                    if (in_last) fs_d = FS_CRC;
                end
            end
            FS_CRC: begin
                if (abort_req) begin
                    fs_d = FS_IDLE;
                end else begin
                    want_prim = 1'b0;
                    body_w    = crc_w;
                    fs_d      = FS_EOF;
                end
            end
            default: begin
                want = PR_EOF;
                fs_d = FS_IDLE;
            end
        endcase
    end

    lnk_tx_cont u_cont (
        .clk       (clk),
        .rst       (rst),
        .want_prim (want_prim),
        .prim      (want),
        .sel       (sel)
    );

    assign scr_adv = (sel == SL_WORD) || (sel == SL_FILL);

    lnk_tx_scr #(.INIT(SCR_INIT)) u_scr (
        .clk     (clk),
        .rst     (rst),
        .restart (sof_go),
        .advance (scr_adv),
        .word    (scr_w)
    );

    lnk_tx_crc #(.INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .restart (sof_go),
        .update  (accept),
        .din     (in_data),
        .crc     (crc_w)
    );

    always_comb begin
        case (sel)
            SL_WORD: lane_d = '{data: body_w ^ scr_w,      ctl: K_DATA};
            SL_PRIM: lane_d = '{data: prim_code(want),     ctl: K_PRIM};
            SL_CONT: lane_d = '{data: prim_code(PR_CONT),  ctl: K_PRIM};
            default: lane_d = '{data: scr_w,              ctl: K_DATA};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q   <= FS_IDLE;
            lane_q <= '{data: prim_code(PR_SYNC), ctl: K_PRIM};
        end else begin
            fs_q   <= fs_d;
            lane_q <= lane_d;
        end
    end

    assign tx_data = lane_q.data;
    assign tx_ctl  = lane_q.ctl;

    // R2
    ctl_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl == K_DATA) || (tx_ctl == K_PRIM));

    // R3
    sof_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl == K_PRIM && tx_data == prim_code(PR_SOF))
        |=> (tx_ctl == K_DATA || tx_data == prim_code(PR_SYNC)));

    // R6
    cont_prev_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl == K_PRIM && tx_data == prim_code(PR_CONT))
        |-> ($past(tx_ctl) == K_PRIM && $past(tx_data) != prim_code(PR_CONT)));

    // R7
    abort_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (in_frame && abort_req)
        |=> (tx_ctl == K_PRIM && tx_data == prim_code(PR_SYNC) && fs_q == FS_IDLE));
endmodule

// File: tb/lnk_tx_framer_test.sv
`timescale 1ns/1ps
module lnk_tx_framer_test;
    localparam logic [31:0] C_SYNC = 32'hB5B5957C;
    localparam logic [31:0] C_SOF  = 32'h3737B57C;
    localparam logic [31:0] C_EOF  = 32'hD5D5B57C;
    localparam logic [31:0] C_CONT = 32'h9999AA7C;

    // mode: 0 plain frame, 1 abort after CUT dwords, 2 source gap after CUT dwords,
    //       3 plain frame with an abort pulse in the idle filler
    localparam int NV = 8;
    localparam int V_LEN  [NV] = '{1, 4, 9, 5, 3, 3, 6, 2};
    localparam int V_MODE [NV] = '{0, 0, 0, 1, 1, 1, 2, 3};
    localparam int V_CUT  [NV] = '{0, 0, 0, 2, 0, 3, 4, 0};
    localparam logic [31:0] V_SEED [NV] = '{32'h00000000, 32'h12345678, 32'hCAFEF00D,
        32'h0F0F0F0F, 32'hFFFFFFFF, 32'h80000001, 32'h5A5AA5A5, 32'h13579BDF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        abort_req = 1'b0;
    logic        in_ready;
    logic [31:0] tx_data;
    logic [3:0]  tx_ctl;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    lnk_tx_framer uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .abort_req(abort_req),
        .tx_data(tx_data), .tx_ctl(tx_ctl)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] pay(input logic [31:0] seed, input int i);
        return seed ^ (32'(i) * 32'h9E3779B9);
    endfunction

    function automatic logic [47:0] ref_step(input logic [15:0] st);
        logic [15:0] s;
        logic [31:0] w;
        s = st;
        for (int i = 0; i < 32; i++) begin
            w[i] = s[15];
            s = {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
        end
        return {s, w};
    endfunction

    function automatic logic [31:0] scr_at(input int k);
        logic [47:0] r;
        logic [15:0] s;
        s = 16'hFFFF;
        for (int i = 0; i < k; i++) begin
            r = ref_step(s);
            s = r[47:32];
        end
        r = ref_step(s);
        return r[31:0];
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] seed, input int len);
        logic [31:0] c;
        logic [31:0] d;
        logic        top;
        c = 32'h52325032;
        for (int i = 0; i < len; i++) begin
            d = pay(seed, i);
            for (int b = 31; b >= 0; b--) begin
                top = c[31] ^ d[b];
                c = c << 1;
                if (top) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
            finish_run();
        end
    end

    task automatic run_vec(input int len, input int mode, input int cut, input logic [31:0] seed);
        logic [35:0] cap [32];
        logic [35:0] exp [32];
        string       tg  [32];
        int n, acc, pend, stop;
        bit done;
        n = len + 12;
        acc = 0;
        pend = 0;
        done = 0;
        for (int c = -1; c < n; c++) begin
            @(negedge clk);
            acc += pend;
            pend = 0;
            if (c >= 0) cap[c] = {tx_ctl, tx_data};
            abort_req = 1'b0;
            if ((mode == 1 || mode == 2) && !done && c >= 0 && acc == cut) begin
                done = 1;
                in_valid = 1'b0;
                in_last = 1'b0;
                if (mode == 1) abort_req = 1'b1;
            end else if (done) begin
                in_valid = 1'b0;
            end else begin
                in_valid = (acc < len);
                in_data = pay(seed, acc);
                in_last = (acc == len - 1);
                if (mode == 3 && c == len + 6) abort_req = 1'b1;
            end
            #1 pend = (in_valid && in_ready) ? 1 : 0;
        end
        in_valid = 1'b0;
        in_last = 1'b0;
        abort_req = 1'b0;

        stop = (mode == 1 || mode == 2) ? cut : -1;
        exp[0] = {4'h1, C_SOF};
        tg[0] = "R3 start";
        if (stop < 0) begin
            for (int i = 0; i < len; i++) begin
                exp[1 + i] = {4'h0, pay(seed, i) ^ scr_at(i)};
                tg[1 + i] = "R5 payload";
            end
            exp[len + 1] = {4'h0, ref_crc(seed, len) ^ scr_at(len)};
            tg[len + 1] = "R4 crc";
            exp[len + 2] = {4'h1, C_EOF};
            tg[len + 2] = "R3 end";
            exp[len + 3] = {4'h1, C_SYNC};
            tg[len + 3] = "R10 idle";
            exp[len + 4] = {4'h1, C_SYNC};
            tg[len + 4] = "R6 second";
            exp[len + 5] = {4'h1, C_CONT};
            tg[len + 5] = "R6 cont";
            for (int j = len + 6; j < n; j++) begin
                exp[j] = {4'h0, scr_at(len + 1 + j - (len + 6))};
                tg[j] = (mode == 3 && j >= len + 7) ? "R9 ignored" : "R6 filler";
            end
        end else begin
            for (int i = 0; i < stop; i++) begin
                exp[1 + i] = {4'h0, pay(seed, i) ^ scr_at(i)};
                tg[1 + i] = "R5 payload";
            end
            exp[stop + 1] = {4'h1, C_SYNC};
            tg[stop + 1] = (mode == 1) ? "R7 abort" : "R8 gap";
            exp[stop + 2] = {4'h1, C_SYNC};
            tg[stop + 2] = "R6 second";
            exp[stop + 3] = {4'h1, C_CONT};
            tg[stop + 3] = "R6 cont";
            for (int j = stop + 4; j < n; j++) begin
                exp[j] = {4'h0, scr_at(stop + j - (stop + 4))};
                tg[j] = "R6 filler";
            end
        end
        for (int j = 0; j < n; j++) check(tg[j], cap[j], exp[j]);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset out", {tx_ctl, tx_data}, {4'h1, C_SYNC});
        check("R1 reset ready", {35'd0, in_ready}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 idle sync", {tx_ctl, tx_data}, {4'h1, C_SYNC});
        @(negedge clk);
        check("R6 idle cont", {tx_ctl, tx_data}, {4'h1, C_CONT});
        @(negedge clk);
        check("R5 filler0", {tx_ctl, tx_data}, {4'h0, scr_at(0)});
        @(negedge clk);
        check("R2 filler1", {tx_ctl, tx_data}, {4'h0, scr_at(1)});

        for (int v = 0; v < NV; v++) begin
            run_vec(V_LEN[v], V_MODE[v], V_CUT[v], V_SEED[v]);
            repeat (2) @(negedge clk);
        end

        // R1: reset in the middle of a frame
        in_valid = 1'b1;
        in_data = 32'hA1A2A3A4;
        in_last = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 midframe out", {tx_ctl, tx_data}, {4'h1, C_SYNC});
        check("R1 midframe ready", {35'd0, in_ready}, 36'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset sync", {tx_ctl, tx_data}, {4'h1, C_SYNC});
        @(negedge clk);
        check("R1 after reset cont", {tx_ctl, tx_data}, {4'h1, C_CONT});
        @(negedge clk);
        check("R1 after reset seed", {tx_ctl, tx_data}, {4'h0, scr_at(0)});

        finish_run();
    end
endmodule